// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Read Mode

This block buffers 36-bit words between two independent clocks. Writers push words on the write clock, and readers take them from a registered output on the read clock. A mode input selects how the read side behaves. In standard mode the read-side status is an active-low empty flag, and a word appears at the output only when it is requested. In fall-through mode the read-side status is an output-ready flag, and the oldest word moves into the output register by itself. The write-side status is low only when the memory is full.

Each side also has an almost-empty or almost-full flag. These flags compare the number of words held in memory against offsets that are sampled while reset is high. A word that has already moved into the output register no longer counts as held in memory. Read and write pointers cross between the clocks as Gray code through synchronizer chains. With the default two stages, the standard-mode read flag follows a write after two read-clock edges and fall-through data follows after three.

Top module: `dual_clock_fwft_fifo`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `rd_flag` is 0, `almost_empty_n` is 0, `wr_ready` is 1, `almost_full_n` is 1 and `rd_data` is 0.
- R2: With `fwft_sel`=0, a word written into an empty FIFO on write edge t raises `rd_flag` on read edge t+2 (clocks aligned), and `rd_flag` falls on the read edge that takes the last stored word.
- R3: With `fwft_sel`=0, a read-clock edge with `rd_en`=1 and `rd_flag`=1 loads the oldest stored word into `rd_data`. A read attempted while `rd_flag`=0 is ignored and `rd_data` keeps its word.
- R4: With `fwft_sel`=1, the first word written into an empty FIFO on write edge t appears in `rd_data` on read edge t+3 without any request. `rd_flag` rises on that same edge.
- R5: With `fwft_sel`=1, `rd_en`=1 while `rd_flag`=1 consumes the word in `rd_data`. On that edge the next stored word loads, or, if none is stored, `rd_flag` falls and `rd_data` keeps its value. `rd_en` while `rd_flag`=0 has no effect.
- R6: `almost_empty_n` is 1 exactly when the memory count, as seen by the read side, exceeds the empty offset X. A word held in `rd_data` is not part of that count.
- R7: `almost_full_n` is 0 exactly when the memory count, as seen by the write side, is at least DEPTH−Y.
- R8: `wr_ready` is 0 exactly when the memory holds DEPTH words. A write attempted while it is 0 is dropped.
- R9: The offsets X (`ae_offset`) and Y (`af_offset`) are captured only while `rst` is high. Later changes to them have no effect. `fwft_sel` may change only during reset.
- R10: Words leave in the order they were written, with none lost or duplicated, up to a full memory of DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| fwft_sel | input | 1 | 1 selects fall-through mode, 0 selects standard mode |
| ae_offset | input | $clog2(DEPTH) | Almost-empty offset X, sampled during reset |
| af_offset | input | $clog2(DEPTH) | Almost-full offset Y, sampled during reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to write |
| wr_ready | output | 1 | High while space remains (full flag, active low) |
| almost_full_n | output | 1 | Low when count ≥ DEPTH−Y |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Output register |
| rd_flag | output | 1 | Standard: not-empty; fall-through: output ready |
| almost_empty_n | output | 1 | Low when count ≤ X |

## Verification
The bench builds the block with its defaults: DEPTH=256, DW=36 and two synchronizer stages. It drives both clocks from one 50 MHz source, so the two- and three-edge latencies of R2 and R4 fall on fixed edges and can be checked exactly. At a depth of 256, a full fill and drain takes only a few hundred cycles. That keeps the full flag, the dropped write, and the almost-full threshold at DEPTH−Y within reach. Small offsets (X=1 or 0, Y=4) put the almost-empty edges a word or two from empty, which is where the output-register exclusion shows.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/cdc_sync_chain.sv
module cdc_sync_chain #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_early,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q_early = chain[STAGES-2];
  assign q       = chain[STAGES-1];
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int DW = 36,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] af_off_in,
  input  logic [AW:0]   rgray_early,
  input  logic [AW:0]   rgray_sync,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [AW:0]   wgray,
  output logic          in_ready,
  output logic          almost_full_n
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_CNT = PW'(1) << AW;

  logic [PW-1:0] wbin, wbin_nxt, rbin_early, rbin_sync, fill_nxt;
  logic [AW-1:0] y_q;
  logic          push;

  always_comb begin
    for (int i = 0; i < PW; i++) begin
      rbin_early[i] = ^(rgray_early >> i);
      rbin_sync[i]  = ^(rgray_sync >> i);
    end
  end

  assign push     = wr_en & in_ready;
  assign wbin_nxt = wbin + PW'(push);
  assign fill_nxt = wbin_nxt - rbin_early;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin          <= '0;
      wgray         <= '0;
      in_ready      <= 1'b1;
      almost_full_n <= 1'b1;
      y_q           <= af_off_in;
    end else begin
      wbin          <= wbin_nxt;
      wgray         <= wbin_nxt ^ (wbin_nxt >> 1);
      in_ready      <= (fill_nxt != FULL_CNT);
      almost_full_n <= (fill_nxt < (FULL_CNT - {1'b0, y_q}));
    end
  end

  assign mem_we    = push;
  assign mem_waddr = wbin[AW-1:0];

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (wbin - rbin_sync) <= FULL_CNT);

  assert_af_before_full_R7: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> !almost_full_n);
endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side
  import dcf_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  fifo_mode_e    mode,
  input  logic          rd_en,
  input  logic [AW-1:0] ae_off_in,
  input  logic [AW:0]   wgray_early,
  input  logic [AW:0]   wgray_sync,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic [AW:0]   rgray,
  output logic          out_flag,
  output logic          almost_empty_n
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_CNT = PW'(1) << AW;

  logic [PW-1:0] rbin, rbin_nxt, wbin_early, wbin_sync, cnt_cur, cnt_nxt;
  logic [AW-1:0] x_q;
  logic          load;

  always_comb begin
    for (int i = 0; i < PW; i++) begin
      wbin_early[i] = ^(wgray_early >> i);
      wbin_sync[i]  = ^(wgray_sync >> i);
    end
  end

  assign cnt_cur  = wbin_sync - rbin;
  assign load     = (mode == MODE_FWFT) ? ((cnt_cur != '0) && (!out_flag || rd_en))
                                        : (rd_en && out_flag);
  assign rbin_nxt = rbin + PW'(load);
  assign cnt_nxt  = wbin_early - rbin_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin           <= '0;
      rgray          <= '0;
      out_flag       <= 1'b0;
      almost_empty_n <= 1'b0;
      x_q            <= ae_off_in;
    end else begin
      rbin           <= rbin_nxt;
      rgray          <= rbin_nxt ^ (rbin_nxt >> 1);
      almost_empty_n <= (cnt_nxt > {1'b0, x_q});
      if (mode == MODE_FWFT) out_flag <= load | (out_flag & ~rd_en);
      else                   out_flag <= (cnt_nxt != '0);
    end
  end

  assign mem_re    = load;
  assign mem_raddr = rbin[AW-1:0];

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_cur <= FULL_CNT);

  assert_ready_has_data_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FWFT && $rose(out_flag)) |-> $past(cnt_cur != '0));

  assert_ae_implies_data_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_STD && almost_empty_n) |-> out_flag);
endmodule

// File: rtl/dual_clock_fwft_fifo.sv
module dual_clock_fwft_fifo
  import dcf_pkg::*;
#(
  parameter int DW          = 36,
  parameter int DEPTH       = 256,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          fwft_sel,
  input  logic [AW-1:0] ae_offset,
  input  logic [AW-1:0] af_offset,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic          almost_full_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_flag,
  output logic          almost_empty_n
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wgray, rgray;
  logic [PW-1:0] wgray_e, wgray_s, rgray_e, rgray_s;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_waddr, mem_raddr;
  fifo_mode_e    mode;

  assign mode = fifo_mode_e'(fwft_sel);

  cdc_sync_chain #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst(rst), .d(wgray), .q_early(wgray_e), .q(wgray_s));

  cdc_sync_chain #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst(rst), .d(rgray), .q_early(rgray_e), .q(rgray_s));

  fifo_wr_side #(.AW(AW)) u_wr (
    .clk(wclk), .rst(rst), .wr_en(wr_en), .af_off_in(af_offset),
    .rgray_early(rgray_e), .rgray_sync(rgray_s),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .wgray(wgray),
    .in_ready(wr_ready), .almost_full_n(almost_full_n));

  fifo_rd_side #(.AW(AW)) u_rd (
    .clk(rclk), .rst(rst), .mode(mode), .rd_en(rd_en), .ae_off_in(ae_offset),
    .wgray_early(wgray_e), .wgray_sync(wgray_s),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .rgray(rgray),
    .out_flag(rd_flag), .almost_empty_n(almost_empty_n));

  fifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
    .rclk(rclk), .rst(rst), .re(mem_re), .raddr(mem_raddr), .rdata(rd_data));

  assert_dout_hold_R5: assert property (@(posedge rclk) disable iff (rst)
    (rd_flag && !rd_en) |=> $stable(rd_data));
endmodule

// File: tb/tb_dual_clock_fwft_fifo.sv
module tb_dual_clock_fwft_fifo;
  localparam int DW    = 36;
  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [DW-1:0] DA = 36'hA_5A5A_0000;
  localparam logic [DW-1:0] DB = 36'h3_C3C3_0000;
  localparam logic [DW-1:0] DF = 36'h7_0F0F_0000;

  // row: {wr, rd, exp_flag, exp_ae, exp_dout}, standard mode, X=1
  localparam int ROWS = 8;
  localparam logic [DW+3:0] TBL [ROWS] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 36'h0},
    {1'b1, 1'b0, 1'b0, 1'b0, 36'h0},
    {1'b1, 1'b0, 1'b1, 1'b0, 36'h0},
    {1'b0, 1'b0, 1'b1, 1'b1, 36'h0},
    {1'b0, 1'b1, 1'b1, 1'b1, DA + 36'd0},
    {1'b0, 1'b1, 1'b1, 1'b0, DA + 36'd1},
    {1'b0, 1'b1, 1'b0, 1'b0, DA + 36'd2},
    {1'b0, 1'b1, 1'b0, 1'b0, DA + 36'd2}
  };

  logic          clk = 1'b0;
  logic          rst, fwft_sel, wr_en, rd_en;
  logic [AW-1:0] ae_offset, af_offset;
  logic [DW-1:0] wr_data, rd_data;
  logic          wr_ready, almost_full_n, rd_flag, almost_empty_n;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  dual_clock_fwft_fifo #(.DW(DW), .DEPTH(DEPTH)) dut (
    .wclk(clk), .rclk(clk), .rst(rst), .fwft_sel(fwft_sel),
    .ae_offset(ae_offset), .af_offset(af_offset),
    .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
    .almost_full_n(almost_full_n), .rd_en(rd_en), .rd_data(rd_data),
    .rd_flag(rd_flag), .almost_empty_n(almost_empty_n));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic mode, input logic [AW-1:0] x, input logic [AW-1:0] y);
    rst = 1'b1; fwft_sel = mode; ae_offset = x; af_offset = y;
    wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    repeat (4) cycle();
    rst = 1'b0;
  endtask

  initial begin
    do_reset(1'b0, 8'd1, 8'd4);
    chk(rd_flag == 1'b0,        "R1 rd_flag",        64'(rd_flag), 64'd0);
    chk(almost_empty_n == 1'b0, "R1 almost_empty_n", 64'(almost_empty_n), 64'd0);
    chk(wr_ready == 1'b1,       "R1 wr_ready",       64'(wr_ready), 64'd1);
    chk(almost_full_n == 1'b1,  "R1 almost_full_n",  64'(almost_full_n), 64'd1);
    chk(rd_data == '0,          "R1 rd_data",        64'(rd_data), 64'd0);

    // vector table: R2 flag latency, R3 reads and ignored reads, R6 threshold
    begin
      int nw = 0;
      for (int r = 0; r < ROWS; r++) begin
        wr_en   = TBL[r][DW+3];
        rd_en   = TBL[r][DW+2];
        wr_data = DA + DW'(nw);
        if (wr_en) nw++;
        cycle();
        chk(rd_flag == TBL[r][DW+1],        "R2 rd_flag row",  64'(rd_flag), 64'(TBL[r][DW+1]));
        chk(almost_empty_n == TBL[r][DW],   "R6 ae row",       64'(almost_empty_n), 64'(TBL[r][DW]));
        chk(rd_data == TBL[r][DW-1:0],      "R3 rd_data row",  64'(rd_data), 64'(TBL[r][DW-1:0]));
      end
      wr_en = 1'b0; rd_en = 1'b0;
    end

    // fill to full: R7 threshold, R8 full and dropped write, R10 order
    do_reset(1'b0, 8'd1, 8'd4);
    for (int i = 0; i < DEPTH; i++) begin
      wr_en = 1'b1; wr_data = DB + DW'(i);
      cycle();
      if (i + 1 == DEPTH - 5) chk(almost_full_n == 1'b1, "R7 af below threshold", 64'(almost_full_n), 64'd1);
      if (i + 1 == DEPTH - 4) chk(almost_full_n == 1'b0, "R7 af at threshold",    64'(almost_full_n), 64'd0);
      if (i + 1 == DEPTH - 1) chk(wr_ready == 1'b1,      "R8 ready one short",    64'(wr_ready), 64'd1);
      if (i + 1 == DEPTH)     chk(wr_ready == 1'b0,      "R8 ready at full",      64'(wr_ready), 64'd0);
    end
    wr_data = 36'hF_FFFF_FFFF;
    cycle();
    wr_en = 1'b0;
    repeat (3) cycle();
    begin
      int got = 0;
      int mism = 0;
      logic [DW-1:0] first_bad = '0;
      while (rd_flag && got < DEPTH + 8) begin
        rd_en = 1'b1;
        cycle();
        if (rd_data != DB + DW'(got)) begin
          if (mism == 0) first_bad = rd_data;
          mism++;
        end
        got++;
      end
      rd_en = 1'b0;
      chk(got == DEPTH, "R8 dropped write, words read", 64'(got), 64'(DEPTH));
      chk(mism == 0,    "R10 order of data",           64'(first_bad), 64'(DB));
    end
    repeat (3) cycle();
    chk(wr_ready == 1'b1, "R8 ready after drain", 64'(wr_ready), 64'd1);

    // fall-through mode: R4, R5, R6, R9
    do_reset(1'b1, 8'd0, 8'd0);
    ae_offset = 8'd200; af_offset = 8'd200;
    chk(rd_flag == 1'b0, "R1 fwft rd_flag", 64'(rd_flag), 64'd0);
    wr_en = 1'b1; wr_data = DF;
    cycle();
    wr_en = 1'b0;
    cycle();
    chk(rd_flag == 1'b0, "R4 ready after edge 1", 64'(rd_flag), 64'd0);
    cycle();
    chk(rd_flag == 1'b0, "R4 ready after edge 2", 64'(rd_flag), 64'd0);
    chk(rd_data == '0,   "R4 data after edge 2",  64'(rd_data), 64'd0);
    cycle();
    chk(rd_flag == 1'b1, "R4 ready after edge 3", 64'(rd_flag), 64'd1);
    chk(rd_data == DF,   "R4 data after edge 3",  64'(rd_data), 64'(DF));
    chk(almost_empty_n == 1'b0, "R6 output word not counted", 64'(almost_empty_n), 64'd0);
    wr_en = 1'b1; wr_data = DF + 36'd1;
    cycle();
    wr_en = 1'b0;
    cycle();
    cycle();
    chk(almost_empty_n == 1'b1, "R9 X captured at reset (R6)", 64'(almost_empty_n), 64'd1);
    chk(rd_data == DF,          "R5 data held without read",   64'(rd_data), 64'(DF));
    rd_en = 1'b1;
    cycle();
    chk(rd_data == DF + 36'd1,  "R5 next word on read",  64'(rd_data), 64'(DF + 36'd1));
    chk(rd_flag == 1'b1,        "R5 ready stays",        64'(rd_flag), 64'd1);
    chk(almost_empty_n == 1'b0, "R6 count back to zero", 64'(almost_empty_n), 64'd0);
    cycle();
    chk(rd_flag == 1'b0,        "R5 ready falls",        64'(rd_flag), 64'd0);
    chk(rd_data == DF + 36'd1,  "R5 data kept",          64'(rd_data), 64'(DF + 36'd1));
    cycle();
    chk(rd_flag == 1'b0,        "R5 read ignored flag",  64'(rd_flag), 64'd0);
    chk(rd_data == DF + 36'd1,  "R5 read ignored data",  64'(rd_data), 64'(DF + 36'd1));
    chk(almost_full_n == 1'b1,  "R9 Y captured at reset (R7)", 64'(almost_full_n), 64'd1);
    rd_en = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule